// File: doc/BRIEF.md
# PHY Management Register File with Indirect Chip Window

This block holds the management registers of a PHY-like device that runs only at 100 Mb/s in full duplex. A management front end, which already handles the serial framing, presents decoded transactions to it: a 5-bit register number, a write strobe, a read strobe and a 16-bit write value. The block answers reads with a ready pulse and a 16-bit value. It holds a control register at number 0 and a capability register at number 1. It exports loopback and isolate controls, and a device reset pulse that clears itself.

Register numbers 16 and 17 form an address/data window into a larger internal chip register space. Writing number 16 latches an internal address. A write to number 17 is forwarded as a single-cycle write on a simple internal register bus. A read of number 17 raises a read request on that bus and waits for an acknowledge before it answers the front end. The stored internal address stays in place, so repeated window accesses reach the same internal register.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After `rst_n` is released, `loopback_en` is 0, `isolate_en` is 1, `dev_reset` is 0, and register 0 reads 0x2500.
- R2: A read of any register number other than 17 raises `mg_rdy` for exactly one cycle, in the cycle after the one in which `mg_rd` was sampled, with the value in `mg_rdata`.
- R3: A write to register 0 copies bit 14 to `loopback_en` and bit 10 to `isolate_en`. Register 0 always reads bit 13 = 1 and bit 8 = 1, and reads bits 12, 11, 9, 7, 6 and 5..0 as 0, whatever value was written.
- R4: A write to register 0 with bit 15 set raises `dev_reset` for exactly RST_CYCLES (default 8) cycles, starting the next cycle. During the pulse, bit 15 reads 1, `loopback_en` is 0 and `isolate_en` is 1. Writes to register 0 during the pulse are ignored. Bit 15 reads 0 once the pulse ends.
- R5: Register 1 reads 0x4000: bit 14 (100BASE-X full duplex) is 1 and every other bit is 0.
- R6: A write to register 16 stores bits IAW-1..0 of the value. A read of register 16 returns that address zero-extended to 16 bits.
- R7: A write to register 17 produces a one-cycle `ib_wr` pulse in the next cycle, with `ib_addr` equal to the stored address and `ib_wdata` equal to the written value.
- R8: A read of register 17 raises `ib_rd` from the next cycle and holds it until `ib_ack` is sampled high. `mg_rdy` then pulses in the following cycle, with `mg_rdata` equal to the `ib_rdata` present at the acknowledge.
- R9: Accesses to register 17 leave the stored internal address unchanged.
- R10: Reads of register numbers other than 0, 1, 16 and 17 return 0x0000. Writes to those numbers change no register.
- R11: While a read of register 17 is waiting for its acknowledge, new `mg_rd` and `mg_wr` strobes are ignored. When `mg_wr` and `mg_rd` are high in the same cycle, only the write is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mg_addr | input | 5 | Management register number |
| mg_wr | input | 1 | Management write strobe |
| mg_rd | input | 1 | Management read strobe |
| mg_wdata | input | 16 | Management write value |
| mg_rdata | output | 16 | Management read value, valid with mg_rdy |
| mg_rdy | output | 1 | One-cycle read-complete pulse |
| loopback_en | output | 1 | Loopback control |
| isolate_en | output | 1 | MII isolate control |
| dev_reset | output | 1 | Device reset pulse |
| ib_addr | output | IAW | Internal bus address |
| ib_wr | output | 1 | Internal bus write pulse |
| ib_rd | output | 1 | Internal bus read request, held until acknowledge |
| ib_wdata | output | 16 | Internal bus write value |
| ib_rdata | input | 16 | Internal bus read value |
| ib_ack | input | 1 | Internal bus read acknowledge |

## Verification
Reads of register 17 are tried with acknowledge latencies from zero to three cycles. This separates a design that samples the internal read data at the acknowledge from one that samples it at a fixed delay. Register 0 is written with values whose fixed-bit positions are all ones, which exposes any fixed bit that a write can change. Strobes are issued during a pending window read and during a reset pulse, and a write and a read are issued together; these separate correct blocking from late or partial blocking. A random mix over every implemented number and over unimplemented numbers checks that register 16 survives window traffic.

// File: rtl/phy_mgmt_pkg.sv
// Shared constants and types for the management register file.
// Assumes 5-bit register numbers and 16-bit register values.
package phy_mgmt_pkg;

    localparam logic [4:0] REG_CTRL = 5'd0;
    localparam logic [4:0] REG_STAT = 5'd1;
    localparam logic [4:0] REG_IDX  = 5'd16;
    localparam logic [4:0] REG_WIN  = 5'd17;

    // Capability word: only 100BASE-X full duplex advertised.
    localparam logic [15:0] STAT_WORD = 16'h4000;

    // One decoded management operation; at most one field is set.
    typedef struct packed {
        logic wr_ctrl;
        logic wr_idx;
        logic wr_win;
        logic rd_win;
        logic rd_local;
    } mg_op_t;

    // Assemble the control register from its live fields.
    function automatic logic [15:0] ctrl_word(input logic rst, input logic lb,
                                              input logic iso);
        return {rst, lb, 1'b1, 2'b00, iso, 1'b0, 1'b1, 2'b00, 6'b000000};
    endfunction

endpackage

// File: rtl/pmr_access_decode.sv
// Turns raw management strobes into one decoded operation.
// Assumes the front end pulses a strobe for one cycle per access; strobes
// arriving while busy is high are dropped, and a write wins over a read.
module pmr_access_decode
    import phy_mgmt_pkg::*;
(
    input  logic [4:0] mg_addr,
    input  logic       mg_wr,
    input  logic       mg_rd,
    input  logic       busy,
    output mg_op_t     op
);

    logic wr_ok;
    logic rd_ok;

    // Gate the strobes: busy blocks everything, write has priority.
    always_comb begin
        wr_ok = mg_wr && !busy;
        rd_ok = mg_rd && !mg_wr && !busy;
    end

    // Select the operation by register number.
    always_comb begin
        op          = '0;
        op.wr_ctrl  = wr_ok && (mg_addr == REG_CTRL);
        op.wr_idx   = wr_ok && (mg_addr == REG_IDX);
        op.wr_win   = wr_ok && (mg_addr == REG_WIN);
        op.rd_win   = rd_ok && (mg_addr == REG_WIN);
        op.rd_local = rd_ok && (mg_addr != REG_WIN);
    end

endmodule

// File: rtl/pmr_ctrl_reg.sv
// Control register: loopback, isolate and a self-clearing device reset.
// Assumes RST_CYCLES >= 1. The reset pulse forces loopback off and isolate
// on; control writes arriving during the pulse are dropped.
module pmr_ctrl_reg
    import phy_mgmt_pkg::*;
#(
    parameter int RST_CYCLES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_rst,
    input  logic        wr_lb,
    input  logic        wr_iso,
    output logic        loopback,
    output logic        isolate,
    output logic        rst_active,
    output logic [15:0] word
);

    localparam int CW = $clog2(RST_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(RST_CYCLES);

    logic [CW-1:0] rst_cnt;

    // Reset pulse counter: load on a reset write, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_cnt <= '0;
        end else if (wr_en && wr_rst && rst_cnt == '0) begin
            rst_cnt <= CNT_LOAD;
        end else if (rst_cnt != '0) begin
            rst_cnt <= rst_cnt - 1'b1;
        end
    end

    // Loopback and isolate bits: written values, overridden by a reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loopback <= 1'b0;
            isolate  <= 1'b1;
        end else if (wr_en && rst_cnt == '0) begin
            if (wr_rst) begin
                loopback <= 1'b0;
                isolate  <= 1'b1;
            end else begin
                loopback <= wr_lb;
                isolate  <= wr_iso;
            end
        end
    end

    // Readable view with fixed capability bits.
    always_comb begin
        rst_active = (rst_cnt != '0);
        word       = ctrl_word(rst_active, loopback, isolate);
    end

endmodule

// File: rtl/pmr_window.sv
// Indirect access window: address latch plus internal bus sequencer.
// Assumes the internal bus takes writes in one cycle without a handshake
// and acknowledges reads with ib_ack while ib_rd is high.
module pmr_window #(
    parameter int IAW = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_idx,
    input  logic           wr_win,
    input  logic           rd_win,
    input  logic [15:0]    wdata,
    input  logic           ib_ack,
    input  logic [15:0]    ib_rdata,
    output logic [IAW-1:0] idx_q,
    output logic [IAW-1:0] ib_addr,
    output logic           ib_wr,
    output logic           ib_rd,
    output logic [15:0]    ib_wdata,
    output logic           win_done,
    output logic [15:0]    win_data,
    output logic           busy
);

    logic pend;

    // Internal address latch, written only through register 16.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (wr_idx) begin
            idx_q <= wdata[IAW-1:0];
        end
    end

    // Write forwarding: one-cycle pulse carrying the value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ib_wr    <= 1'b0;
            ib_wdata <= '0;
        end else begin
            ib_wr <= wr_win;
            if (wr_win) begin
                ib_wdata <= wdata;
            end
        end
    end

    // Read request: raised on a window read, dropped at the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (rd_win) begin
            pend <= 1'b1;
        end else if (pend && ib_ack) begin
            pend <= 1'b0;
        end
    end

    // Bus outputs and completion view for the response path.
    always_comb begin
        ib_addr  = idx_q;
        ib_rd    = pend;
        busy     = pend;
        win_done = pend && ib_ack;
        win_data = ib_rdata;
    end

endmodule

// File: rtl/pmr_resp.sv
// Read response path: selects the local register value or the window
// result and presents it with a one-cycle ready pulse.
// Assumes rd_local and win_done never rise in the same cycle.
module pmr_resp
    import phy_mgmt_pkg::*;
#(
    parameter int IAW = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rd_local,
    input  logic [4:0]     rd_addr,
    input  logic [15:0]    ctrl_val,
    input  logic [IAW-1:0] idx_q,
    input  logic           win_done,
    input  logic [15:0]    win_data,
    output logic           rdy,
    output logic [15:0]    rdata
);

    logic [15:0] idx_ext;
    logic [15:0] local_val;

    // Zero-extend the stored internal address to a register value.
    generate
        if (IAW >= 16) begin : g_idx_full
            assign idx_ext = idx_q[15:0];
        end else begin : g_idx_pad
            assign idx_ext = {{(16 - IAW){1'b0}}, idx_q};
        end
    endgenerate

    // Local register multiplexer; unimplemented numbers read zero.
    always_comb begin
        case (rd_addr)
            REG_CTRL: local_val = ctrl_val;
            REG_STAT: local_val = STAT_WORD;
            REG_IDX:  local_val = idx_ext;
            default:  local_val = 16'h0000;
        endcase
    end

    // Register the answer and the ready pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy   <= 1'b0;
            rdata <= '0;
        end else begin
            rdy <= rd_local || win_done;
            if (rd_local) begin
                rdata <= local_val;
            end else if (win_done) begin
                rdata <= win_data;
            end
        end
    end

endmodule

// File: rtl/phy_mgmt_regs.sv
// Management register file top: control and capability registers plus an
// address/data window onto an internal chip register bus.
// Assumes decoded, single-cycle management strobes and IAW <= 16.
module phy_mgmt_regs
    import phy_mgmt_pkg::*;
#(
    parameter int IAW        = 10,
    parameter int RST_CYCLES = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [4:0]     mg_addr,
    input  logic           mg_wr,
    input  logic           mg_rd,
    input  logic [15:0]    mg_wdata,
    output logic [15:0]    mg_rdata,
    output logic           mg_rdy,
    output logic           loopback_en,
    output logic           isolate_en,
    output logic           dev_reset,
    output logic [IAW-1:0] ib_addr,
    output logic           ib_wr,
    output logic           ib_rd,
    output logic [15:0]    ib_wdata,
    input  logic [15:0]    ib_rdata,
    input  logic           ib_ack
);

    mg_op_t         op;
    logic           busy;
    logic [15:0]    ctrl_val;
    logic [IAW-1:0] idx_q;
    logic           win_done;
    logic [15:0]    win_data;

    pmr_access_decode u_dec (
        .mg_addr (mg_addr),
        .mg_wr   (mg_wr),
        .mg_rd   (mg_rd),
        .busy    (busy),
        .op      (op)
    );

    pmr_ctrl_reg #(.RST_CYCLES(RST_CYCLES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (op.wr_ctrl),
        .wr_rst     (mg_wdata[15]),
        .wr_lb      (mg_wdata[14]),
        .wr_iso     (mg_wdata[10]),
        .loopback   (loopback_en),
        .isolate    (isolate_en),
        .rst_active (dev_reset),
        .word       (ctrl_val)
    );

    pmr_window #(.IAW(IAW)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_idx   (op.wr_idx),
        .wr_win   (op.wr_win),
        .rd_win   (op.rd_win),
        .wdata    (mg_wdata),
        .ib_ack   (ib_ack),
        .ib_rdata (ib_rdata),
        .idx_q    (idx_q),
        .ib_addr  (ib_addr),
        .ib_wr    (ib_wr),
        .ib_rd    (ib_rd),
        .ib_wdata (ib_wdata),
        .win_done (win_done),
        .win_data (win_data),
        .busy     (busy)
    );

    pmr_resp #(.IAW(IAW)) u_resp (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_local (op.rd_local),
        .rd_addr  (mg_addr),
        .ctrl_val (ctrl_val),
        .idx_q    (idx_q),
        .win_done (win_done),
        .win_data (win_data),
        .rdy      (mg_rdy),
        .rdata    (mg_rdata)
    );

endmodule

// File: rtl/pmr_checker.sv
// Protocol checker for phy_mgmt_regs, attached with bind.
// Tracks the reset pulse length with a counter instead of a long $past.
module pmr_checker #(
    parameter int IAW        = 10,
    parameter int RST_CYCLES = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [4:0]     mg_addr,
    input logic           mg_wr,
    input logic           mg_rdy,
    input logic           loopback_en,
    input logic           isolate_en,
    input logic           dev_reset,
    input logic [IAW-1:0] ib_addr,
    input logic           ib_wr,
    input logic           ib_rd,
    input logic           ib_ack
);

    logic [15:0] run;

    // Count consecutive cycles with the reset pulse high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= '0;
        end else if (dev_reset) begin
            run <= run + 1'b1;
        end else begin
            run <= '0;
        end
    end

    AST_RST_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        dev_reset |-> (run < 16'(RST_CYCLES))); // R4
    AST_RST_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_reset) |-> (run == 16'(RST_CYCLES))); // R4
    AST_RST_FORCES_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        dev_reset |-> (isolate_en && !loopback_en)); // R4
    AST_WR_FROM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ib_wr |-> ($past(mg_wr) && $past(mg_addr) == 5'd17)); // R7
    AST_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_rd && !ib_ack) |=> ib_rd); // R8
    AST_RDY_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_rd && ib_ack) |=> (mg_rdy && !ib_rd)); // R8
    AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_rd && $past(ib_rd)) |-> $stable(ib_addr)); // R9
    AST_NO_WR_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        !(ib_rd && ib_wr)); // R11

endmodule

bind phy_mgmt_regs pmr_checker #(.IAW(IAW), .RST_CYCLES(RST_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mg_addr     (mg_addr),
    .mg_wr       (mg_wr),
    .mg_rdy      (mg_rdy),
    .loopback_en (loopback_en),
    .isolate_en  (isolate_en),
    .dev_reset   (dev_reset),
    .ib_addr     (ib_addr),
    .ib_wr       (ib_wr),
    .ib_rd       (ib_rd),
    .ib_ack      (ib_ack)
);

// File: tb/phy_mgmt_regs_tb.sv
// Bench: behavioural reference model compared with the DUT every cycle,
// plus directed checks on reset, fixed bits, reset pulse and window reads.
module phy_mgmt_regs_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int IAW        = 10;
    localparam int RSTC       = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [4:0]     mg_addr = '0;
    logic           mg_wr = 1'b0;
    logic           mg_rd = 1'b0;
    logic [15:0]    mg_wdata = '0;
    logic [15:0]    mg_rdata;
    logic           mg_rdy;
    logic           loopback_en;
    logic           isolate_en;
    logic           dev_reset;
    logic [IAW-1:0] ib_addr;
    logic           ib_wr;
    logic           ib_rd;
    logic [15:0]    ib_wdata;
    logic [15:0]    ib_rdata = '0;
    logic           ib_ack = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    int lat   = 0;
    int lat_cnt = 0;
    logic [15:0] mem [0:(1<<IAW)-1];

    phy_mgmt_regs #(.IAW(IAW), .RST_CYCLES(RSTC)) dut_i (
        .clk(clk), .rst_n(rst_n), .mg_addr(mg_addr), .mg_wr(mg_wr),
        .mg_rd(mg_rd), .mg_wdata(mg_wdata), .mg_rdata(mg_rdata),
        .mg_rdy(mg_rdy), .loopback_en(loopback_en), .isolate_en(isolate_en),
        .dev_reset(dev_reset), .ib_addr(ib_addr), .ib_wr(ib_wr),
        .ib_rd(ib_rd), .ib_wdata(ib_wdata), .ib_rdata(ib_rdata),
        .ib_ack(ib_ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // ---------------- reference model ----------------
    bit          m_lb, m_iso, m_rdy, m_pend, m_wr;
    int          m_rcnt;
    logic [15:0] m_rdata, m_wdata;
    logic [IAW-1:0] m_idx;
    string       m_tag = "R2";

    function automatic logic [15:0] m_reg0(int rc, bit lb, bit iso);
        logic [15:0] v;
        v = 16'h2100;
        v[15] = (rc != 0);
        v[14] = lb;
        v[10] = iso;
        return v;
    endfunction

    always @(posedge clk) begin
        int old_rc;
        if (!rst_n) begin
            m_lb = 0; m_iso = 1; m_rdy = 0; m_pend = 0; m_wr = 0;
            m_rcnt = 0; m_rdata = '0; m_wdata = '0; m_idx = '0;
        end else begin
            old_rc = m_rcnt;
            if (m_rcnt > 0) m_rcnt--;
            m_wr  = 0;
            m_rdy = 0;
            if (m_pend) begin
                if (ib_ack) begin
                    m_pend = 0; m_rdy = 1; m_rdata = ib_rdata; m_tag = "R8";
                end
            end else if (mg_wr) begin
                if (mg_addr == 0 && old_rc == 0) begin
                    if (mg_wdata[15]) begin
                        m_rcnt = RSTC; m_lb = 0; m_iso = 1;
                    end else begin
                        m_lb = mg_wdata[14]; m_iso = mg_wdata[10];
                    end
                end else if (mg_addr == 16) begin
                    m_idx = mg_wdata[IAW-1:0];
                end else if (mg_addr == 17) begin
                    m_wr = 1; m_wdata = mg_wdata;
                end
            end else if (mg_rd) begin
                m_rdy = 1;
                case (mg_addr)
                    0:  begin m_rdata = m_reg0(old_rc, m_lb, m_iso); m_tag = "R3"; end
                    1:  begin m_rdata = 16'h4000; m_tag = "R5"; end
                    16: begin m_rdata = 16'(m_idx); m_tag = "R6"; end
                    17: begin m_rdy = 0; m_pend = 1; end
                    default: begin m_rdata = 16'h0000; m_tag = "R10"; end
                endcase
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (rst_n) begin
            check(loopback_en == m_lb, "R3 loopback_en", loopback_en, m_lb);
            check(isolate_en == m_iso, "R3 isolate_en", isolate_en, m_iso);
            check(dev_reset == (m_rcnt != 0), "R4 dev_reset", dev_reset, m_rcnt != 0);
            check(mg_rdy == m_rdy, "R2 mg_rdy", mg_rdy, m_rdy);
            if (m_rdy) check(mg_rdata == m_rdata, m_tag, mg_rdata, m_rdata);
            check(ib_wr == m_wr, "R7 ib_wr", ib_wr, m_wr);
            check(ib_rd == m_pend, "R8 ib_rd", ib_rd, m_pend);
            if (m_wr) check(ib_wdata == m_wdata, "R7 ib_wdata", ib_wdata, m_wdata);
            if (m_wr || m_pend) check(ib_addr == m_idx, "R9 ib_addr", ib_addr, m_idx);
        end
    end

    // ---------------- internal bus responder ----------------
    always @(negedge clk) begin
        if (ib_wr) mem[ib_addr] = ib_wdata;
        if (ib_ack) begin
            ib_ack = 0;
        end else if (ib_rd) begin
            if (lat_cnt >= lat) begin
                ib_ack = 1; ib_rdata = mem[ib_addr]; lat_cnt = 0;
            end else begin
                lat_cnt++;
            end
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            check(0, "watchdog", cyc, 0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic mg_write(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        mg_addr = a; mg_wdata = d; mg_wr = 1;
        @(negedge clk);
        mg_wr = 0;
    endtask

    task automatic mg_read(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        mg_addr = a; mg_rd = 1;
        @(negedge clk);
        mg_rd = 0;
        while (!mg_rdy) @(negedge clk);
        d = mg_rdata;
    endtask

    initial begin
        logic [15:0] v;
        for (int i = 0; i < (1 << IAW); i++) mem[i] = 16'(i * 37 + 5);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state at the ports, then register 0 value
        check(loopback_en == 0 && isolate_en == 1 && dev_reset == 0,
              "R1 reset outputs", {loopback_en, isolate_en, dev_reset}, 3'b010);
        mg_read(5'd0, v);
        check(v == 16'h2500, "R1 reg0 after reset", v, 16'h2500);
        mg_read(5'd1, v);
        check(v == 16'h4000, "R5 capability", v, 16'h4000);
        // R3: fixed bits cannot be written
        mg_write(5'd0, 16'h7BFF);
        mg_read(5'd0, v);
        check(v == 16'h6100, "R3 fixed bits", v, 16'h6100);
        mg_write(5'd0, 16'h0400);
        mg_read(5'd0, v);
        check(v == 16'h2500, "R3 isolate set", v, 16'h2500);
        mg_write(5'd0, 16'h4000);
        // R4: reset pulse, write during pulse ignored, bit 15 reads 1
        mg_write(5'd0, 16'h8000);
        mg_write(5'd0, 16'h4000);
        mg_read(5'd0, v);
        check(v == 16'hA500, "R4 reg0 during pulse", v, 16'hA500);
        repeat (RSTC) @(negedge clk);
        mg_read(5'd0, v);
        check(v == 16'h2500, "R4 reg0 after pulse", v, 16'h2500);
        // R6: index register truncation and readback
        mg_write(5'd16, 16'hFFFF);
        mg_read(5'd16, v);
        check(v == 16'h03FF, "R6 index readback", v, 16'h03FF);
        // R7/R8/R9: window write then reads at several latencies
        mg_write(5'd16, 16'h0123);
        mg_write(5'd17, 16'hBEEF);
        for (int l = 0; l < 4; l++) begin
            lat = l;
            mg_read(5'd17, v);
            check(v == 16'hBEEF, "R8 window read", v, 16'hBEEF);
        end
        mg_read(5'd16, v);
        check(v == 16'h0123, "R9 index kept", v, 16'h0123);
        // R10: unimplemented numbers
        mg_write(5'd5, 16'hFFFF);
        mg_read(5'd5, v);
        check(v == 16'h0000, "R10 unimplemented read", v, 0);
        mg_read(5'd31, v);
        check(v == 16'h0000, "R10 top number read", v, 0);
        mg_read(5'd0, v);
        check(v == 16'h2500, "R10 write had no effect", v, 16'h2500);
        // R11: write during a pending window read is dropped
        lat = 3;
        @(negedge clk);
        mg_addr = 5'd17; mg_rd = 1;
        @(negedge clk);
        mg_rd = 0; mg_addr = 5'd0; mg_wdata = 16'h4000; mg_wr = 1;
        @(negedge clk);
        mg_wr = 0;
        while (!mg_rdy) @(negedge clk);
        mg_read(5'd0, v);
        check(v == 16'h2500, "R11 write while pending", v, 16'h2500);
        // R11: write and read together, write wins
        @(negedge clk);
        mg_addr = 5'd16; mg_wdata = 16'h0055; mg_wr = 1; mg_rd = 1;
        @(negedge clk);
        mg_wr = 0; mg_rd = 0;
        @(negedge clk);
        check(mg_rdy == 0, "R11 simultaneous no ready", mg_rdy, 0);
        mg_read(5'd16, v);
        check(v == 16'h0055, "R11 simultaneous write done", v, 16'h0055);
        // Random mix, compared by the model every cycle
        for (int k = 0; k < 400; k++) begin
            logic [4:0] a;
            int sel;
            sel = $urandom_range(0, 5);
            a = (sel == 0) ? 5'd0 : (sel == 1) ? 5'd1 : (sel == 2) ? 5'd16 :
                (sel == 5) ? 5'($urandom_range(0, 31)) : 5'd17;
            lat = $urandom_range(0, 3);
            if ($urandom_range(0, 1) == 1) mg_write(a, 16'($urandom()) & 16'h7FFF);
            else mg_read(a, v);
        end
        repeat (12) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule